// File: doc/BRIEF.md
# Software Flow-Control Transmit Gate

This block decides, one clock at a time, whether a serial transmitter may start its next character. It watches the characters coming in on the receive side (a byte plus a valid strobe) and compares each one with two programmable control codes: one that halts transmission and one that releases it. The block holds a two-state result, running or halted. It drives a transmit-allow output, which the transmitter samples only when it is about to begin a character. A character that is already on the line therefore always finishes, and a halt takes effect at the next character boundary.

In-band control is switched on by an enable input. With the enable clear, the block stays in the running state whatever arrives. A mode input widens the release condition so that any received character except the halt code restarts transmission. A one-cycle host command pulse forces the block back to running. The two control codes reset to 8'h11 (release) and 8'h13 (halt), and each can be rewritten through a write strobe and a shared data bus. All state changes are registered, so an event seen at one rising edge shows on the outputs just after that edge.

Top module: `xonxoff_tx_gate`

## Requirements
- R1: After a synchronous reset the block is running (tx_allow=1, halted=0), and the codes return to release=8'h11 and halt=8'h13.
- R2: With inband_en=0, a received halt code has no effect and tx_allow stays 1, whatever the implied_xon setting.
- R3: With inband_en=1 and the block running, a valid received character equal to the halt code sets halted=1 and tx_allow=0 from the next clock.
- R4: With inband_en=1 and implied_xon=0, a halted block resumes on a valid character equal to the release code. Any other non-halt character leaves it halted.
- R5: With inband_en=1, a host_resume pulse returns a halted block to running on the next clock.
- R6: With inband_en=1 and implied_xon=1, a halted block resumes on any valid character other than the halt code.
- R7: A halt code received while already halted keeps the block halted, in both modes.
- R8: Clearing inband_en while halted returns the block to running on the next clock.
- R9: Writing a new code through release_we or halt_we with code_wdata takes effect from the next clock. The previous value then no longer matches.
- R10: When host_resume and a halt code arrive in the same cycle, host_resume wins and the block is running afterwards.
- R11: rx_char is ignored while rx_valid=0, so the state holds.
- R12: tx_allow is always the inverse of halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | W | Received character |
| inband_en | input | 1 | Enables in-band flow control |
| implied_xon | input | 1 | Any non-halt character releases a halt |
| host_resume | input | 1 | Host command pulse that forces running |
| release_we | input | 1 | Write strobe for the release code |
| halt_we | input | 1 | Write strobe for the halt code |
| code_wdata | input | W | Data for code writes |
| tx_allow | output | 1 | Transmitter may start the next character |
| halted | output | 1 | Block is in the halted state |

## Verification
The assertions check on every cycle the relations that a single clock step decides. These are the output complement (R12), running after reset (R1), the forced release by the host pulse or by a cleared enable (R5, R8, R10), a halt on a matched halt code (R3), and holding while nothing valid arrives (R11). Other behaviour needs a sequence of events, so only the bench's scenarios can show it. This covers the difference between the two release modes, rewriting the codes and the old code then being ignored, and the codes returning to their defaults after a reset in the middle of a run.

// File: rtl/xg_pkg.sv
package xg_pkg;

    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HALT = 1'b1
    } flow_state_e;

    typedef struct packed {
        logic hit_release;
        logic hit_halt;
        logic any_char;
    } rx_class_t;

    typedef struct packed {
        logic enable;
        logic implied;
        logic host_go;
    } flow_ctl_t;

    localparam int NUM_CODES = 2;
    localparam int IDX_RELEASE = 0;
    localparam int IDX_HALT = 1;

    // Next-state rule: a cleared enable or a host command forces running;
    // a halt match always wins over a release match.
    function automatic flow_state_e next_state(flow_state_e cur,
                                               flow_ctl_t ctl,
                                               rx_class_t cls);
        flow_state_e nxt;
        nxt = cur;
        if (!ctl.enable || ctl.host_go) begin
            nxt = FLOW_RUN;
        end else begin
            unique case (cur)
                FLOW_RUN: begin
                    if (cls.hit_halt) nxt = FLOW_HALT;
                end
                FLOW_HALT: begin
                    if (cls.hit_halt)
                        nxt = FLOW_HALT;
                    else if (cls.hit_release)
                        nxt = FLOW_RUN;
                    else if (ctl.implied && cls.any_char)
                        nxt = FLOW_RUN;
                end
                default: nxt = FLOW_RUN;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/xg_code_reg.sv
module xg_code_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= INIT;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/xg_char_match.sv
module xg_char_match
    import xg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         valid,
    input  logic [W-1:0] ch,
    input  logic [W-1:0] release_code,
    input  logic [W-1:0] halt_code,
    output rx_class_t    cls
);
    always_comb begin
        cls.any_char    = valid;
        cls.hit_halt    = valid && (ch == halt_code);
        cls.hit_release = valid && (ch == release_code);
    end
endmodule

// File: rtl/xg_flow_fsm.sv
module xg_flow_fsm
    import xg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flow_ctl_t ctl,
    input  rx_class_t cls,
    output logic      allow,
    output logic      stopped
);
    flow_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FLOW_RUN;
        else
            state_q <= next_state(state_q, ctl, cls);
    end

    assign stopped = (state_q == FLOW_HALT);
    assign allow   = (state_q == FLOW_RUN);
endmodule

// File: rtl/xonxoff_tx_gate.sv
module xonxoff_tx_gate
    import xg_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] RELEASE_INIT = 8'h11,
    parameter logic [W-1:0] HALT_INIT = 8'h13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_char,
    input  logic         inband_en,
    input  logic         implied_xon,
    input  logic         host_resume,
    input  logic         release_we,
    input  logic         halt_we,
    input  logic [W-1:0] code_wdata,
    output logic         tx_allow,
    output logic         halted
);
    logic [NUM_CODES-1:0]        code_we;
    logic [NUM_CODES-1:0][W-1:0] code_q;
    logic [W-1:0]                release_code;
    logic [W-1:0]                halt_code;
    rx_class_t                   cls;
    flow_ctl_t                   ctl;

    assign code_we[IDX_RELEASE] = release_we;
    assign code_we[IDX_HALT]    = halt_we;

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
        localparam logic [W-1:0] INIT_K = (k == IDX_RELEASE) ? RELEASE_INIT : HALT_INIT;
        xg_code_reg #(.W(W), .INIT(INIT_K)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (code_we[k]),
            .wdata (code_wdata),
            .q     (code_q[k])
        );
    end

    assign release_code = code_q[IDX_RELEASE];
    assign halt_code    = code_q[IDX_HALT];

    xg_char_match #(.W(W)) u_match (
        .valid        (rx_valid),
        .ch           (rx_char),
        .release_code (release_code),
        .halt_code    (halt_code),
        .cls          (cls)
    );

    always_comb begin
        ctl.enable  = inband_en;
        ctl.implied = implied_xon;
        ctl.host_go = host_resume;
    end

    xg_flow_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .cls     (cls),
        .allow   (tx_allow),
        .stopped (halted)
    );
endmodule

// File: rtl/xg_gate_checker.sv
module xg_gate_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         rx_valid,
    input logic [W-1:0] rx_char,
    input logic         inband_en,
    input logic         host_resume,
    input logic [W-1:0] halt_code,
    input logic         tx_allow,
    input logic         halted
);
    assert_complement_R12: assert property (@(posedge clk)
        tx_allow == !halted);

    assert_reset_runs_R1: assert property (@(posedge clk)
        rst |=> (tx_allow && !halted));

    assert_disable_release_R8: assert property (@(posedge clk) disable iff (rst)
        !inband_en |=> tx_allow);

    assert_host_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (inband_en && host_resume) |=> tx_allow);

    assert_halt_on_code_R3: assert property (@(posedge clk) disable iff (rst)
        (inband_en && !host_resume && rx_valid && rx_char == halt_code) |=> halted);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (inband_en && !host_resume && !rx_valid) |=> $stable(halted));
endmodule

bind xonxoff_tx_gate xg_gate_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_char     (rx_char),
    .inband_en   (inband_en),
    .host_resume (host_resume),
    .halt_code   (halt_code),
    .tx_allow    (tx_allow),
    .halted      (halted)
);

// File: tb/xonxoff_tx_gate_test.sv
module xonxoff_tx_gate_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       inband_en = 1'b0;
    logic       implied_xon = 1'b0;
    logic       host_resume = 1'b0;
    logic       release_we = 1'b0;
    logic       halt_we = 1'b0;
    logic [7:0] code_wdata = '0;
    logic       tx_allow;
    logic       halted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  allow;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xonxoff_tx_gate uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
        .inband_en(inband_en), .implied_xon(implied_xon), .host_resume(host_resume),
        .release_we(release_we), .halt_we(halt_we), .code_wdata(code_wdata),
        .tx_allow(tx_allow), .halted(halted)
    );

    // Driver: apply one cycle of stimulus at a falling edge and queue the
    // expected outputs visible just after the following rising edge.
    task automatic step(input logic r, input logic en, input logic imp,
                        input logic rv, input logic [7:0] ch, input logic host,
                        input logic rwe, input logic hwe, input logic [7:0] wd,
                        input logic exp_allow, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; inband_en = en; implied_xon = imp; rx_valid = rv; rx_char = ch;
        host_resume = host; release_we = rwe; halt_we = hwe; code_wdata = wd;
        e.allow = exp_allow;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (tx_allow !== e.allow || halted !== !e.allow) begin
                    errors++;
                    $display("FAIL %s: tx_allow=%b halted=%b expected tx_allow=%b halted=%b",
                             e.tag, tx_allow, halted, e.allow, !e.allow);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        //     rst en imp rv ch    host rwe hwe wd     allow tag
        step(1, 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, "R1 reset");
        step(0, 0, 0, 1, 8'h13, 0, 0, 0, 8'h00, 1, "R2 halt code, enable clear");
        step(0, 0, 1, 1, 8'h13, 0, 0, 0, 8'h00, 1, "R2 halt code, enable clear, implied");
        step(0, 1, 0, 0, 8'h13, 0, 0, 0, 8'h00, 1, "R11 halt code not valid");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt code stops");
        step(0, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 0, "R11 idle holds halt");
        step(0, 1, 0, 1, 8'h41, 0, 0, 0, 8'h00, 0, "R4 other char no resume");
        step(0, 1, 0, 0, 8'h11, 0, 0, 0, 8'h00, 0, "R11 release code not valid");
        step(0, 1, 0, 1, 8'h11, 0, 0, 0, 8'h00, 1, "R4 release code resumes");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt again");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R7 halt while halted");
        step(0, 1, 0, 0, 8'h00, 1, 0, 0, 8'h00, 1, "R5 host resume");
        step(0, 1, 1, 1, 8'h41, 0, 0, 0, 8'h00, 1, "R6 implied, running stays running");
        step(0, 1, 1, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt in implied mode");
        step(0, 1, 1, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R7 halt code not a resume char");
        step(0, 1, 1, 1, 8'h41, 0, 0, 0, 8'h00, 1, "R6 any char resumes");
        step(0, 1, 1, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt");
        step(0, 1, 1, 1, 8'h00, 0, 0, 0, 8'h00, 1, "R6 zero char resumes");
        step(0, 1, 1, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt");
        step(0, 1, 1, 0, 8'h00, 1, 0, 0, 8'h00, 1, "R5 host resume in implied mode");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R3 halt");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, "R8 enable cleared releases");
        step(0, 0, 0, 1, 8'h13, 0, 0, 0, 8'h00, 1, "R8 stays running while clear");
        step(0, 1, 0, 1, 8'h13, 1, 0, 0, 8'h00, 1, "R10 host beats halt code");
        step(0, 1, 0, 0, 8'h00, 0, 0, 1, 8'h55, 1, "R9 write halt code");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 1, "R9 old halt code ignored");
        step(0, 1, 0, 1, 8'h55, 0, 0, 0, 8'h00, 0, "R9 new halt code stops");
        step(0, 1, 0, 1, 8'h11, 0, 0, 0, 8'h00, 1, "R4 default release resumes");
        step(0, 1, 0, 0, 8'h00, 0, 1, 0, 8'h77, 1, "R9 write release code");
        step(0, 1, 0, 1, 8'h55, 0, 0, 0, 8'h00, 0, "R9 halt with new code");
        step(0, 1, 0, 1, 8'h11, 0, 0, 0, 8'h00, 0, "R9 old release code ignored");
        step(0, 1, 0, 1, 8'h77, 0, 0, 0, 8'h00, 1, "R9 new release code resumes");
        step(0, 1, 0, 1, 8'h55, 0, 0, 0, 8'h00, 0, "R3 halt before reset");
        step(1, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, "R1 reset from halted");
        step(0, 1, 0, 1, 8'h13, 0, 0, 0, 8'h00, 0, "R1 default halt code restored");
        step(0, 1, 0, 1, 8'h11, 0, 0, 0, 8'h00, 1, "R1 default release code restored");
        step(0, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1, "R11 idle running");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule